// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Controller

This block gathers interrupt requests from a parameterised number of device slots and folds them into a single request line for the processor. Each slot holds three things: a local enable, a sticky pending flag and a programmable vector. A slot records a request from its device only while its enable is set.

When the processor answers with a one-cycle acknowledge pulse, the pulse travels along a chain of slots, from slot 0 towards the last slot. The first slot that has an enabled pending request stops the pulse and puts its vector on the vector bus in that same cycle. Its pending flag clears on the clock edge that ends the cycle. If no slot claims the pulse, the bus carries an all-ones spurious vector. There is no central priority encoder: position in the chain alone sets priority.

A global enable gates the whole controller. It drops on every accepted acknowledge, which marks handler entry, and comes back on a return pulse from the processor. Software sets up the slots and the global enable through a write-only, memory-mapped port.

Top module: `irq_daisy_ctrl`

## Requirements
- R1: `irq_out` is high exactly when the global enable is set and at least one slot has both its pending flag and its local enable set. Both state bits are registered, so `irq_out` follows them one cycle after the change.
- R2: A `dev_req` bit seen while that slot's local enable is clear is not recorded. Enabling the slot later does not raise `irq_out`.
- R3: During an accepted acknowledge cycle, the enabled pending slot with the lowest index drives its vector on `vec_bus`. Slot 0 has the highest priority.
- R4: The winning slot stops the acknowledge from reaching later slots. Their pending requests stay recorded and are served by later acknowledges, in index order.
- R5: The winner's pending flag clears at the clock edge that closes the acknowledge cycle. If its `dev_req` is still asserted, with the slot enabled, at that edge, the flag stays set.
- R6: An accepted acknowledge with no enabled pending slot drives `vec_bus` to all ones.
- R7: An acknowledge while the global enable is clear is ignored. `vec_bus` reads all ones, and no pending flag changes.
- R8: The global enable clears at the edge after an accepted acknowledge. It sets at the edge after an `intr_ret` pulse. An accepted acknowledge takes precedence over `intr_ret`, and `intr_ret` takes precedence over a register write.
- R9: Writes use the following map and fields:
  - Address k, for k below N_SLOTS, loads slot k: bit VEC_W is the local enable and bits VEC_W-1:0 are the vector.
  - Address N_SLOTS loads the global enable from bit 0.
  - Reset clears every enable, pending flag and vector, and the global enable.
- R10: A pending slot whose local enable is cleared is skipped by the chain and left out of `irq_out`. It keeps its pending flag, so re-enabling it restores the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | N_SLOTS | Per-slot device request, sampled every cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | clog2(N_SLOTS+1) | Register write address |
| wr_data | input | VEC_W+1 | Register write data |
| intr_ack | input | 1 | Single-cycle acknowledge from the processor (handler entry) |
| intr_ret | input | 1 | Single-cycle return-from-handler pulse |
| irq_out | output | 1 | Combined interrupt request |
| vec_bus | output | VEC_W | Vector of the winning slot, or all ones |

## Verification
The in-RTL assertions check the following on every cycle:
- At most one slot claims an acknowledge.
- An unclaimed or blocked acknowledge yields the all-ones vector.
- A disabled, idle slot never becomes pending.
- A winner's flag drops after service unless it is re-requested.
- The global enable falls after every accepted acknowledge and rises after a return.

Some behaviours can only be shown by the bench's scenarios. These are the priority order across several simultaneous requests, the survival of losing requests across acknowledges, requests dropped while a slot was disabled, pending state kept while a slot is disabled, acknowledges ignored under a cleared global enable, and reprogrammed vectors appearing on the bus.

// File: rtl/irq_pkg.sv
package irq_pkg;
   // Address width needed to reach every slot plus the global-enable register.
   function automatic int addr_bits(input int n_slots);
      int w;
      w = 1;
      while ((1 << w) < (n_slots + 1)) w++;
      return w;
   endfunction
endpackage

// File: rtl/irq_gate.sv
module irq_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic ack_in,
   input  logic ret_in,
   input  logic sw_we,
   input  logic sw_val,
   output logic gie,
   output logic ack_eff
);
   logic gie_q;

   assign ack_eff = ack_in & gie_q;
   assign gie     = gie_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       gie_q <= 1'b0;
      else if (ack_eff) gie_q <= 1'b0;
      else if (ret_in)  gie_q <= 1'b1;
      else if (sw_we)   gie_q <= sw_val;
   end

   assert_gie_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ack_eff |=> !gie_q);
   assert_gie_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_in && !ack_eff) |=> gie_q);
endmodule

// File: rtl/irq_chain_link.sv
module irq_chain_link #(
   parameter int VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dev_req,
   input  logic             cfg_we,
   input  logic [VEC_W:0]   cfg_data,
   input  logic             ack_in,
   output logic             ack_out,
   output logic             req_out,
   output logic             grant,
   output logic [VEC_W-1:0] vec_out
);
   logic             en_q;
   logic             pend_q;
   logic [VEC_W-1:0] vec_q;

   assign req_out = pend_q & en_q;
   assign grant   = ack_in & req_out;
   assign ack_out = ack_in & ~req_out;
   assign vec_out = grant ? vec_q : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         vec_q <= '0;
      end else if (cfg_we) begin
         en_q  <= cfg_data[VEC_W];
         vec_q <= cfg_data[VEC_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                pend_q <= 1'b0;
      else if (dev_req && en_q)  pend_q <= 1'b1;
      else if (grant)            pend_q <= 1'b0;
   end

   assert_no_capture_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !pend_q) |=> !pend_q);
   assert_pend_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && !(dev_req && en_q)) |=> !pend_q);
endmodule

// File: rtl/irq_vec_merge.sv
module irq_vec_merge #(
   parameter int N_SLOTS = 4,
   parameter int VEC_W   = 8
) (
   input  logic [N_SLOTS*VEC_W-1:0] vecs,
   input  logic [N_SLOTS-1:0]       grants,
   output logic [VEC_W-1:0]         vec_bus
);
   logic [VEC_W-1:0] acc [N_SLOTS+1];

   assign acc[0] = '0;
   for (genvar i = 0; i < N_SLOTS; i++) begin : g_or
      assign acc[i+1] = acc[i] | vecs[i*VEC_W +: VEC_W];
   end

   assign vec_bus = (|grants) ? acc[N_SLOTS] : {VEC_W{1'b1}};

   always_comb begin
      assert_spurious_R6: assert ((|grants) || (vec_bus == {VEC_W{1'b1}}));
   end
endmodule

// File: rtl/irq_daisy_ctrl.sv
module irq_daisy_ctrl #(
   parameter  int N_SLOTS = 4,
   parameter  int VEC_W   = 8,
   localparam int ADDR_W  = irq_pkg::addr_bits(N_SLOTS),
   localparam int DATA_W  = VEC_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_SLOTS-1:0] dev_req,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               intr_ack,
   input  logic               intr_ret,
   output logic               irq_out,
   output logic [VEC_W-1:0]   vec_bus
);
   if (N_SLOTS < 1) begin : g_bad_slots
      $error("N_SLOTS must be at least 1");
   end
   if (VEC_W < 1) begin : g_bad_vec
      $error("VEC_W must be at least 1");
   end

   localparam logic [ADDR_W-1:0] GIE_ADDR = ADDR_W'(N_SLOTS);

   logic                     gie;
   logic                     ack_eff;
   logic [N_SLOTS:0]         ack_chain;
   logic [N_SLOTS-1:0]       req_vec;
   logic [N_SLOTS-1:0]       grant_vec;
   logic [N_SLOTS*VEC_W-1:0] vec_flat;

   irq_gate u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .ack_in  (intr_ack),
      .ret_in  (intr_ret),
      .sw_we   (wr_en && (wr_addr == GIE_ADDR)),
      .sw_val  (wr_data[0]),
      .gie     (gie),
      .ack_eff (ack_eff)
   );

   assign ack_chain[0] = ack_eff;

   for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
      irq_chain_link #(.VEC_W(VEC_W)) u_link (
         .clk      (clk),
         .rst_n    (rst_n),
         .dev_req  (dev_req[i]),
         .cfg_we   (wr_en && (wr_addr == ADDR_W'(i))),
         .cfg_data (wr_data),
         .ack_in   (ack_chain[i]),
         .ack_out  (ack_chain[i+1]),
         .req_out  (req_vec[i]),
         .grant    (grant_vec[i]),
         .vec_out  (vec_flat[i*VEC_W +: VEC_W])
      );
   end

   irq_vec_merge #(.N_SLOTS(N_SLOTS), .VEC_W(VEC_W)) u_merge (
      .vecs    (vec_flat),
      .grants  (grant_vec),
      .vec_bus (vec_bus)
   );

   assign irq_out = gie & (|req_vec);

   assert_single_winner_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_vec));
   assert_gated_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (intr_ack && !gie) |-> (vec_bus == {VEC_W{1'b1}}));
   assert_chain_winner_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_eff && (|req_vec)) |-> (|grant_vec));
endmodule

// File: tb/irq_daisy_ctrl_tb.sv
module irq_daisy_ctrl_tb;
   localparam int CLK_P = 10;
   localparam int NS    = 4;
   localparam int VW    = 8;
   localparam int AW    = irq_pkg::addr_bits(NS);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] dev_req = '0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [VW:0]   wr_data = '0;
   logic          intr_ack = 1'b0;
   logic          intr_ret = 1'b0;
   logic          irq_out;
   logic [VW-1:0] vec_bus;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [VW-1:0] exp_q [$];
   string         tag_q [$];

   irq_daisy_ctrl #(.N_SLOTS(NS), .VEC_W(VW)) u_dut (
      .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .intr_ack(intr_ack),
      .intr_ret(intr_ret), .irq_out(irq_out), .vec_bus(vec_bus)
   );

   always #(CLK_P/2) clk = ~clk;

   // Monitor: pops the scoreboard on every acknowledge cycle.
   always @(negedge clk) begin
      if (intr_ack) begin
         n_chk++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL scoreboard empty: vec_bus=%h expected none", vec_bus);
         end else begin
            automatic logic [VW-1:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            if (vec_bus !== e) begin
               n_fail++;
               $display("FAIL %s: vec_bus=%h expected %h", t, vec_bus, e);
            end
         end
      end
   end

   task automatic wr(input int a, input logic en, input logic [VW-1:0] v);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = {en, v};
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic set_gie(input logic v);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_addr = AW'(NS); wr_data = {{VW{1'b0}}, v};
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic pulse_req(input logic [NS-1:0] m);
      @(posedge clk); #1;
      dev_req = m;
      @(posedge clk); #1;
      dev_req = '0;
   endtask

   task automatic do_ack(input logic [VW-1:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(posedge clk); #1;
      intr_ack = 1'b1;
      @(posedge clk); #1;
      intr_ack = 1'b0;
   endtask

   task automatic do_ret();
      @(posedge clk); #1;
      intr_ret = 1'b1;
      @(posedge clk); #1;
      intr_ret = 1'b0;
   endtask

   task automatic chk_irq(input logic e, input string t);
      #1;
      n_chk++;
      if (irq_out !== e) begin
         n_fail++;
         $display("FAIL %s: irq_out=%b expected %b", t, irq_out, e);
      end
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run hung, actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      chk_irq(1'b0, "R9 reset irq low");

      // Slot k vector 0x10+k; slot 2 left disabled (R9 map).
      wr(0, 1'b1, 8'h10);
      wr(1, 1'b1, 8'h11);
      wr(2, 1'b0, 8'h12);
      wr(3, 1'b1, 8'h13);
      set_gie(1'b1);

      // R2: request to a disabled slot is dropped.
      pulse_req(4'b0100);
      wr(2, 1'b1, 8'h12);
      chk_irq(1'b0, "R2 disabled request not kept");

      // R6: acknowledge with nothing pending.
      do_ack(8'hFF, "R6 spurious vector");
      do_ret();

      // R1, R3, R4, R8
      pulse_req(4'b1010);
      chk_irq(1'b1, "R1 irq with pending");
      do_ack(8'h11, "R3 slot1 wins over slot3");
      chk_irq(1'b0, "R8 gie cleared on ack");
      do_ret();
      chk_irq(1'b1, "R8 gie set on ret / R4 slot3 kept");
      do_ack(8'h13, "R4 blocked slot served next");
      do_ret();
      chk_irq(1'b0, "R5 pending cleared after service");

      // R7: ack ignored while gie clear.
      pulse_req(4'b0001);
      set_gie(1'b0);
      chk_irq(1'b0, "R1 gie clear masks irq");
      do_ack(8'hFF, "R7 ack ignored when gie clear");
      set_gie(1'b1);
      chk_irq(1'b1, "R7 pending untouched by ignored ack");
      do_ack(8'h10, "R3 slot0 highest priority");
      do_ret();

      // R5: request held through the acknowledge re-arms.
      @(posedge clk); #1 dev_req = 4'b0010;
      do_ack(8'h11, "R5 held request first service");
      dev_req = '0;
      do_ret();
      chk_irq(1'b1, "R5 held request re-armed");
      do_ack(8'h11, "R5 re-armed request served");
      do_ret();
      chk_irq(1'b0, "R5 cleared after release");

      // R10: disabled pending slot is skipped but retained.
      pulse_req(4'b0101);
      wr(0, 1'b0, 8'h10);
      do_ack(8'h12, "R10 disabled slot0 skipped");
      do_ret();
      chk_irq(1'b0, "R10 disabled pending excluded");
      wr(0, 1'b1, 8'h10);
      chk_irq(1'b1, "R10 re-enable restores request");
      do_ack(8'h10, "R10 retained pending served");
      do_ret();

      // R9: reprogrammed vector appears.
      wr(3, 1'b1, 8'hA5);
      pulse_req(4'b1000);
      do_ack(8'hA5, "R9 reprogrammed vector");
      do_ret();

      repeat (2) @(posedge clk);
      n_chk++;
      if (exp_q.size() != 0) begin
         n_fail++;
         $display("FAIL R3 scoreboard: %0d left expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule